// File: doc/BRIEF.md
# Buffered Ping-Pong PWM Channel Pair

A free-running 16-bit up-counter with a programmable modulo drives two compare channels. Each channel produces a PWM output whose active phase runs from the counter rollover until the counter reaches the channel's compare value. The output is driven active only at rollover and inactive only at a compare match. It never toggles, so a zero width gives a true 0% duty and a wrong output state corrects itself within one period.

The two channels can be linked into one buffered PWM output that drives only the first pin. While linked, the two compare registers take turns as the width source. Writing either register arms a pending update. At the next rollover the register written most recently becomes the width source, so a width change always starts on a period boundary. While linked, the second pin is handed to general-purpose I/O, and writes to the second channel's control register are dropped. Software writes 16-bit values through an 8-bit port, upper byte first. Sticky flags report rollover and compare events.

Top module: `pwm_pair_buf`

## Requirements
- R1: The counter steps by one per clock from 0 up to the modulo value and then returns to 0, so the period is modulo + 1 clocks. The overflow flag sets on the edge where the count returns to 0.
- R2: Word registers sit in byte pairs, upper byte at the even address: modulo at 0/1, compare 0 at 2/3, compare 1 at 4/5. A write to the upper byte alone changes no value. The lower-byte write loads the full 16-bit value.
- R3: Unlinked, an enabled non-inverted channel is high in exactly those cycles of a period where the count is below its compare value. A value of 0 gives 0%, and any value above the modulo gives 100%.
- R4: An output goes active only at rollover and inactive only at a compare match. In unlinked mode, raising the compare value after the match has passed gives no second pulse in that period, and the new width applies from the next period.
- R5: Writing control 0 (address 6) with bit 2 set links the pair. The first output's width then comes from compare 0 at once, ch1_gpio_o goes high, and pwm1_o is held low.
- R6: While linked, a lower-byte write to either compare register leaves the width of the current period unchanged. The new width starts at the next rollover.
- R7: While linked, at each rollover the width source becomes the compare register written last. A period with no writes keeps the previous width.
- R8: While linked, writes to control 1 (address 7) are dropped, and the control 1 value in place before linking is used again after unlinking.
- R9: Clearing bit 2 of control 0 keeps buffered operation until the next rollover. At that rollover ch1_gpio_o falls and both channels run independently, the first from compare 0.
- R10: Control bit 0 enables an output and bit 1 selects active-low. A disabled output is held low.
- R11: Flags at address 8 are bit 0 overflow, bit 1 compare 0 and bit 2 compare 1. A compare flag sets on the edge where the count reaches the active width, writing 1 clears a bit, and a set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 8 | Register write data |
| pwm0_o | output | 1 | First channel output, or the buffered output when linked |
| pwm1_o | output | 1 | Second channel output, held low when linked |
| ch1_gpio_o | output | 1 | High while the second pin is released to general-purpose I/O |
| ovf_flag_o | output | 1 | Sticky counter rollover flag |
| cmp_flag_o | output | 2 | Sticky compare flags, bit i for channel i |

## Verification
The bench raises a compare value just after its match has passed. A design that sets its output on any match would show a second pulse in that period. In linked mode it writes a smaller width before the current match. A design that applies the width at once would cut the running pulse short.

Two writes in one period, second register first and then first register, check that the last write wins. A design that favours the second register would show the wrong width in the next period. Compare 1 is written before linking, so a pending state left over from before linking would show up as a wrong source. The bench also unlinks while the width source is compare 1 and checks that the first output falls back to compare 0. Other cases covered are a zero width, a width of modulo and of modulo + 1, an upper byte written alone, and a control 1 write made while linked that must not appear after unlinking.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int unsigned AW   = 4;
  localparam int unsigned NREG = 3;  // modulo, compare 0, compare 1

  localparam logic [AW-1:0] A_CTL0 = 4'd6;
  localparam logic [AW-1:0] A_CTL1 = 4'd7;
  localparam logic [AW-1:0] A_FLAG = 4'd8;

  typedef struct packed {
    logic link;
    logic pol;
    logic en;
  } ctl0_t;

  typedef struct packed {
    logic pol;
    logic en;
  } ctl1_t;
endpackage

// File: rtl/pwm_word_reg.sv
module pwm_word_reg #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4,
  parameter logic [AW-1:0] HI_ADDR = '0,
  parameter logic [2*DW-1:0] RST_VAL = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [DW-1:0]   wr_data_i,
  output logic [2*DW-1:0] val_o,
  output logic [2*DW-1:0] val_nxt_o,
  output logic            commit_o
);
  localparam int unsigned WW = 2 * DW;
  localparam logic [AW-1:0] LO_ADDR = HI_ADDR + AW'(1);

  logic [DW-1:0] hold_q;
  logic [WW-1:0] val_q;
  logic          hi_wr, lo_wr;

  assign hi_wr     = wr_en_i && (wr_addr_i == HI_ADDR);
  assign lo_wr     = wr_en_i && (wr_addr_i == LO_ADDR);
  assign val_nxt_o = lo_wr ? {hold_q, wr_data_i} : val_q;
  assign val_o     = val_q;
  assign commit_o  = lo_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      val_q  <= RST_VAL;
    end else begin
      if (hi_wr) hold_q <= wr_data_i;
      val_q <= val_nxt_o;
    end
  end

  p_hi_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_wr |=> $stable(val_q));
  p_lo_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_wr |=> (val_q[DW-1:0] == $past(wr_data_i)));
endmodule

// File: rtl/pwm_tick_cnt.sv
module pwm_tick_cnt #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] mod_i,
  output logic [CW-1:0] cnt_nxt_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q;

  assign wrap_o    = (cnt_q == mod_i);
  assign cnt_nxt_o = wrap_o ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end

  p_wrap_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_o |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pwm_edge_out.sv
module pwm_edge_out #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wrap_i,
  input  logic [CW-1:0] cnt_nxt_i,
  input  logic [CW-1:0] width_nxt_i,
  output logic          act_o,
  output logic          hit_o
);
  logic act_q, act_d;

  assign hit_o = (cnt_nxt_i == width_nxt_i);

  // set at rollover, clear on match; never toggle
  always_comb begin
    act_d = act_q;
    if (wrap_i)     act_d = (width_nxt_i != '0);
    else if (hit_o) act_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act_d;
  end

  assign act_o = act_q;

  p_rise_at_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> $past(wrap_i));
  p_match_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !wrap_i) |=> !act_q);
endmodule

// File: rtl/pwm_buf_sel.sv
module pwm_buf_sel #(
  parameter int unsigned CW = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               link_i,
  input  logic               link_set_i,
  input  logic               wrap_i,
  input  logic [1:0]         commit_i,
  input  logic [1:0][CW-1:0] cmp_q_i,
  input  logic [CW-1:0]      cmp_d0_i,
  output logic [CW-1:0]      width_nxt_o
);
  logic          pend_q, pend_d;
  logic          src_q, src_d;
  logic [CW-1:0] width_q, width_d;

  always_comb begin
    pend_d = pend_q;
    src_d  = src_q;
    if (link_set_i) begin
      pend_d = 1'b0;
      src_d  = 1'b0;
    end else if (commit_i[0]) begin
      pend_d = 1'b1;
      src_d  = 1'b0;
    end else if (commit_i[1]) begin
      pend_d = 1'b1;
      src_d  = 1'b1;
    end else if (wrap_i) begin
      pend_d = 1'b0;
    end
  end

  // width swaps only at rollover, from the register written last
  always_comb begin
    width_d = width_q;
    if (link_set_i)                     width_d = cmp_d0_i;
    else if (link_i && wrap_i && pend_q) width_d = cmp_q_i[src_q];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      src_q   <= 1'b0;
      width_q <= '0;
    end else begin
      pend_q  <= pend_d;
      src_q   <= src_d;
      width_q <= width_d;
    end
  end

  assign width_nxt_o = width_d;

  p_mid_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_i && !wrap_i && !link_set_i) |=> $stable(width_q));
  p_link_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_set_i |=> (width_q == $past(cmp_d0_i)));
  p_last_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_i && wrap_i && pend_q && !link_set_i) |=> (width_q == $past(cmp_q_i[src_q])));
endmodule

// File: rtl/pwm_pair_buf.sv
module pwm_pair_buf
  import pwm_pair_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter logic [2*DW-1:0] MOD_RST = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          pwm0_o,
  output logic          pwm1_o,
  output logic          ch1_gpio_o,
  output logic          ovf_flag_o,
  output logic [1:0]    cmp_flag_o
);
  localparam int unsigned CW  = 2 * DW;
  localparam int unsigned NCH = 2;

  logic [NREG-1:0][CW-1:0] word_q, word_d;
  logic [NREG-1:0]         commit;

  for (genvar i = 0; i < NREG; i++) begin : g_word
    pwm_word_reg #(
      .DW     (DW),
      .AW     (AW),
      .HI_ADDR(AW'(2 * i)),
      .RST_VAL((i == 0) ? MOD_RST : '0)
    ) u_word (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en_i),
      .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i),
      .val_o    (word_q[i]),
      .val_nxt_o(word_d[i]),
      .commit_o (commit[i])
    );
  end

  logic [CW-1:0] cnt_nxt;
  logic          wrap;

  pwm_tick_cnt #(.CW(CW)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mod_i    (word_q[0]),
    .cnt_nxt_o(cnt_nxt),
    .wrap_o   (wrap)
  );

  ctl0_t ctl0_q;
  ctl1_t ctl1_q;
  logic  ctl0_wr, ctl1_wr, flag_wr;
  logic  link_q, link_d, link_set;

  assign ctl0_wr  = wr_en_i && (wr_addr_i == A_CTL0);
  assign ctl1_wr  = wr_en_i && (wr_addr_i == A_CTL1);
  assign flag_wr  = wr_en_i && (wr_addr_i == A_FLAG);
  assign link_set = ctl0_wr && wr_data_i[2] && !link_q;

  // link takes hold at once, release waits for rollover
  always_comb begin
    link_d = link_q;
    if (link_set)                          link_d = 1'b1;
    else if (link_q && wrap && !ctl0_q.link) link_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl0_q <= '0;
      ctl1_q <= '0;
      link_q <= 1'b0;
    end else begin
      if (ctl0_wr)            ctl0_q <= ctl0_t'(wr_data_i[2:0]);
      if (ctl1_wr && !link_q) ctl1_q <= ctl1_t'(wr_data_i[1:0]);
      link_q <= link_d;
    end
  end

  logic [CW-1:0] buf_width_d;

  pwm_buf_sel #(.CW(CW)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .link_i     (link_q),
    .link_set_i (link_set),
    .wrap_i     (wrap),
    .commit_i   (commit[2:1]),
    .cmp_q_i    (word_q[2:1]),
    .cmp_d0_i   (word_d[1]),
    .width_nxt_o(buf_width_d)
  );

  logic [NCH-1:0][CW-1:0] width_d;
  logic [NCH-1:0]         act, hit;

  assign width_d[0] = link_d ? buf_width_d : word_d[1];
  assign width_d[1] = word_d[2];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_edge_out #(.CW(CW)) u_out (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wrap_i     (wrap),
      .cnt_nxt_i  (cnt_nxt),
      .width_nxt_i(width_d[c]),
      .act_o      (act[c]),
      .hit_o      (hit[c])
    );
  end

  logic [2:0] flag_q, flag_d, flag_set, flag_clr;

  assign flag_set = {hit[1] & ~link_q, hit[0], wrap};
  assign flag_clr = flag_wr ? wr_data_i[2:0] : 3'b000;
  assign flag_d   = (flag_q & ~flag_clr) | flag_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign pwm0_o     = ctl0_q.en & (act[0] ^ ctl0_q.pol);
  assign pwm1_o     = ~link_q & ctl1_q.en & (act[1] ^ ctl1_q.pol);
  assign ch1_gpio_o = link_q;
  assign ovf_flag_o = flag_q[0];
  assign cmp_flag_o = flag_q[2:1];

  p_mod_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit[0] |=> (word_q[0] == $past(word_d[0])));
  p_ovf_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> ovf_flag_o);
  p_pin_free_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch1_gpio_o |-> !pwm1_o);
  p_unlink_at_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_q) |-> $past(wrap));
  p_cmp_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit[0] |=> cmp_flag_o[0]);
endmodule

// File: tb/pwm_pair_buf_tb.sv
module pwm_pair_buf_tb;
  import pwm_pair_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int MOD        = 19;
  localparam int PER        = MOD + 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [7:0]    wr_data_i = '0;
  logic          pwm0_o, pwm1_o, ch1_gpio_o, ovf_flag_o;
  logic [1:0]    cmp_flag_o;

  int checks = 0;
  int errors = 0;

  pwm_pair_buf u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .pwm0_o    (pwm0_o),
    .pwm1_o    (pwm1_o),
    .ch1_gpio_o(ch1_gpio_o),
    .ovf_flag_o(ovf_flag_o),
    .cmp_flag_o(cmp_flag_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called and returns at a falling edge; one clock per write
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_en_i   = 1'b1;
    wr_addr_i = a;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic wr16(input logic [AW-1:0] hi, input logic [15:0] v);
    wr(hi, v[15:8]);
    wr(hi + AW'(1), v[7:0]);
  endtask

  // returns at the falling edge where the count is 0
  task automatic sync();
    wr(A_FLAG, 8'h01);
    while (!ovf_flag_o) @(negedge clk_i);
  endtask

  task automatic measure(input int n, input int sel, input logic lvl, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      if (((sel == 0) ? pwm0_o : pwm1_o) == lvl) cnt++;
      @(negedge clk_i);
    end
  endtask

  task automatic duty(input int sel, input logic lvl, output int cnt);
    sync();
    measure(PER, sel, lvl, cnt);
  endtask

  task automatic t_reset();
    chk("R10 reset pwm0", int'(pwm0_o), 0);
    chk("R10 reset pwm1", int'(pwm1_o), 0);
    chk("R5 reset gpio", int'(ch1_gpio_o), 0);
    chk("R11 reset flags", int'({cmp_flag_o, ovf_flag_o}), 0);
  endtask

  task automatic t_period();
    int n = 0;
    sync();
    wr(A_FLAG, 8'h01);
    while (!ovf_flag_o) begin
      @(negedge clk_i);
      n++;
    end
    chk("R1 clocks from clear to rollover", n, MOD);
  endtask

  task automatic t_split_write();
    int c;
    wr(A_CTL0, 8'h01);
    wr16(4'd2, 16'd5);
    duty(0, 1'b1, c);
    chk("R2 width 5", c, 5);
    wr(4'd2, 8'h01);
    duty(0, 1'b1, c);
    chk("R2 upper byte alone", c, 5);
    wr(4'd3, 8'h05);
    duty(0, 1'b1, c);
    chk("R2 lower byte loads 0x0105", c, PER);
  endtask

  task automatic t_duty();
    int c;
    wr16(4'd2, 16'd0);
    duty(0, 1'b1, c);
    chk("R3 zero width", c, 0);
    wr16(4'd2, 16'(MOD));
    duty(0, 1'b1, c);
    chk("R3 width equal to modulo", c, MOD);
    wr16(4'd2, 16'(MOD + 1));
    duty(0, 1'b1, c);
    chk("R3 width above modulo", c, PER);
    wr16(4'd2, 16'd7);
    duty(0, 1'b1, c);
    chk("R3 width 7", c, 7);
    wr(A_CTL1, 8'h01);
    wr16(4'd4, 16'd11);
    duty(1, 1'b1, c);
    chk("R3 channel 1 width 11", c, 11);
  endtask

  task automatic t_no_repulse();
    int c;
    wr16(4'd2, 16'd5);
    sync();
    measure(8, 0, 1'b1, c);
    chk("R4 pulse before raise", c, 5);
    wr16(4'd2, 16'd15);
    measure(10, 0, 1'b1, c);
    chk("R4 no second pulse", c, 0);
    measure(PER, 0, 1'b1, c);
    chk("R4 raised width next period", c, 15);
  endtask

  task automatic t_polarity();
    int c;
    wr(A_CTL0, 8'h03);
    wr16(4'd2, 16'd5);
    duty(0, 1'b0, c);
    chk("R10 active-low cycles", c, 5);
    wr(A_CTL0, 8'h00);
    duty(0, 1'b1, c);
    chk("R10 disabled held low", c, 0);
  endtask

  task automatic t_link();
    int c;
    wr16(4'd2, 16'd6);
    wr16(4'd4, 16'd12);
    wr(A_CTL0, 8'h05);
    chk("R5 gpio after link", int'(ch1_gpio_o), 1);
    chk("R5 pwm1 low after link", int'(pwm1_o), 0);
    duty(0, 1'b1, c);
    chk("R5 width from compare 0", c, 6);
    duty(1, 1'b1, c);
    chk("R5 pin 1 released", c, 0);
  endtask

  task automatic t_deferred();
    int c;
    sync();
    wr16(4'd4, 16'd3);
    measure(PER - 2, 0, 1'b1, c);
    chk("R6 current period keeps width 6", c, 4);
    measure(PER, 0, 1'b1, c);
    chk("R6 new width next period", c, 3);
  endtask

  task automatic t_last_wins();
    int c;
    sync();
    wr16(4'd4, 16'd9);
    wr16(4'd2, 16'd14);
    measure(PER - 4, 0, 1'b1, c);
    measure(PER, 0, 1'b1, c);
    chk("R7 compare 0 written last", c, 14);
    sync();
    wr16(4'd4, 16'd9);
    measure(PER - 2, 0, 1'b1, c);
    measure(PER, 0, 1'b1, c);
    chk("R7 compare 1 written last", c, 9);
    measure(PER, 0, 1'b1, c);
    chk("R7 width kept without writes", c, 9);
  endtask

  task automatic t_ch1_ignored();
    int c;
    wr(A_CTL1, 8'h02);
    duty(1, 1'b1, c);
    chk("R8 pwm1 low while linked", c, 0);
  endtask

  task automatic t_unlink();
    int c;
    sync();
    wr(A_CTL0, 8'h01);
    chk("R9 still linked before rollover", int'(ch1_gpio_o), 1);
    measure(PER - 1, 0, 1'b1, c);
    chk("R9 buffered width until rollover", c, 8);
    chk("R9 gpio released at rollover", int'(ch1_gpio_o), 0);
    measure(PER, 0, 1'b1, c);
    chk("R9 independent from compare 0", c, 14);
    duty(1, 1'b1, c);
    chk("R8 control 1 write was dropped", c, 9);
  endtask

  task automatic t_flags();
    int c;
    sync();
    wr(A_FLAG, 8'h06);
    chk("R11 compare 0 flag cleared", int'(cmp_flag_o[0]), 0);
    measure(12, 0, 1'b1, c);
    chk("R11 compare 0 flag before match", int'(cmp_flag_o[0]), 0);
    @(negedge clk_i);
    chk("R11 compare 0 flag at match", int'(cmp_flag_o[0]), 1);
    chk("R11 compare 1 flag at its match", int'(cmp_flag_o[1]), 1);
    wr(A_FLAG, 8'h01);
    chk("R11 overflow flag cleared", int'(ovf_flag_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    wr16(4'd0, 16'(MOD));
    t_period();
    t_split_write();
    t_duty();
    t_no_repulse();
    t_polarity();
    t_link();
    t_deferred();
    t_last_wins();
    t_ch1_ignored();
    t_unlink();
    t_flags();
    summary();
  end
endmodule